// File: doc/BRIEF.md
# Charge Cycle Sequencer

This controller steps a single-cell charger through its cycle. It starts in the off state. After a blanking gap it charges at the pre-charge or fast-charge current. It stops when termination is reached, and it stops with a fault when the safety timer runs out. The analog loops report to it through synchronized comparator flags: battery below the low threshold, CV loop active, current below the termination level, input-voltage, power-path and thermal limiting, and supplement mode. A 3-bit battery temperature zone comes in beside these flags. The enable pin, a disable register bit and the current, scaling and timer fields also arrive as plain inputs.

All time is counted on a single prescaled `tick` strobe. The blanking gap lasts `BLANK_TICKS` ticks. The fast-charge safety limit is `TMR_UNIT << tmr_sel` ticks. A system sets the tick rate to suit its real durations, and a testbench can shrink milliseconds and hours to a few pulses.

States: IDLE, GAP (blanking), PRE, FAST, PAUSE (cold/hot), DONE and FAULT. The transitions are:
- IDLE→GAP when charging is enabled.
- GAP→PRE or GAP→FAST when the gap count completes.
- PRE/FAST→GAP when the target code changes or the battery crosses the low threshold.
- GAP/PRE/FAST→PAUSE in the cold or hot zone, and PAUSE→GAP when the zone clears.
- FAST→DONE on a qualified termination.
- GAP/PRE/FAST→FAULT when the timer expires.
- FAULT→IDLE when the pin is raised or the supply is lost.
- Any state except FAULT→IDLE when the enable condition drops.

Top module: `chg_seq_ctrl`

## Requirements
- R1: `chg_on` can be 1 only when `inhibit_pin` is 0, `dis_bit` is 0 and `vin_ok` is 1. Every other combination keeps charging off.
- R2: While `bat_low` is 1, the applied current code is `pre_code`.
- R3: In the cool zone (`zone` = 3'd1), the fast code applied is floor(`fast_code` × (8 − `cool_fac`) / 8). So `cool_fac` 0 gives the full code and 7 gives one eighth.
- R4: `vreg_warm` is 1 exactly while `zone` = 3'd2 (warm). Zone 3'd0 is normal, and codes 5 to 7 also count as normal.
- R5: When the target code changes, `chg_on` goes low for `BLANK_TICKS` ticks before `cur_code` takes the new value. `cur_code` never changes while `chg_on` is 1.
- R6: FAST moves to DONE (`charge_done` = 1, `chg_on` = 0) only when `cv_active` and `below_term` are both 1 and input-voltage, power-path, thermal and supplement limiting are all 0, outside the warm zone.
- R7: The safety timer runs in GAP, PRE and FAST. In fast charge it expires after `TMR_UNIT << tmr_sel` ticks. While `bat_low` is 1 it expires after one quarter of that. Expiry gives `safety_fault` = 1 and `chg_on` = 0.
- R8: Only `inhibit_pin` high or `vin_ok` low clears `safety_fault`. Writing `dis_bit` leaves it set.
- R9: Any change of `tmr_sel` while the timer runs restarts the timer from zero.
- R10: With `tmr_x2` = 1, the timer advances at half rate whenever thermal, input-voltage or power-path limiting is active, or the zone is cool or warm.
- R11: In the cold (3'd3) or hot (3'd4) zone, charging stops within one cycle and the safety timer holds its count.
- R12: After reset, `chg_on`, `cur_code`, `safety_fault` and `charge_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled time-base strobe |
| inhibit_pin | input | 1 | Enable pin, high inhibits charging |
| dis_bit | input | 1 | Register bit, 1 disables charging |
| vin_ok | input | 1 | Input supply valid |
| bat_low | input | 1 | Battery below low-voltage threshold |
| cv_active | input | 1 | Constant-voltage loop in control |
| below_term | input | 1 | Charge current at or below termination level |
| vindpm_act | input | 1 | Input-voltage limiting loop active |
| dppm_act | input | 1 | Power-path limiting loop active |
| therm_act | input | 1 | Thermal foldback loop active |
| supp_act | input | 1 | Battery supplement mode active |
| zone | input | 3 | Temperature zone: 0 normal, 1 cool, 2 warm, 3 cold, 4 hot |
| fast_code | input | CUR_W | Fast-charge current code |
| pre_code | input | CUR_W | Pre-charge current code |
| cool_fac | input | 3 | Cool-zone reduction in eighths |
| tmr_sel | input | SEL_W | Safety-timer duration select |
| tmr_x2 | input | 1 | Half-rate timer option |
| chg_on | output | 1 | Charge FET enable |
| cur_code | output | CUR_W | Applied current code |
| vreg_warm | output | 1 | Select reduced regulation voltage |
| safety_fault | output | 1 | Safety timer fault |
| charge_done | output | 1 | Charge terminated |

## Verification
The target-code path is driven with a sequence of zone, battery-level and code patterns:
- normal and pre-charge, which show which code source is selected;
- cool with scale factors 7, 4 and 0, which show the rounding and the no-reduction end;
- warm, which shows the voltage select without a current change;
- cold and hot, which show the pause.

Termination is offered while each blocking condition is held in turn, and only the clean case may reach DONE. The safety timer is run to one tick short of its limit and then to the limit in four settings: plain fast charge, pre-charge, half rate, and across a pause. Each pair of checks separates a correct count from one that is off by a factor or by one.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_PRE,
        ST_FAST,
        ST_PAUSE,
        ST_DONE,
        ST_FAULT
    } chg_state_e;

    localparam logic [2:0] ZN_NORMAL = 3'd0;
    localparam logic [2:0] ZN_COOL   = 3'd1;
    localparam logic [2:0] ZN_WARM   = 3'd2;
    localparam logic [2:0] ZN_COLD   = 3'd3;
    localparam logic [2:0] ZN_HOT    = 3'd4;

endpackage

// File: rtl/chg_isel.sv
module chg_isel #(
    parameter int CUR_W = 8
) (
    input  logic             bat_low,
    input  logic [2:0]       zone,
    input  logic [CUR_W-1:0] fast_code,
    input  logic [CUR_W-1:0] pre_code,
    input  logic [2:0]       cool_fac,
    output logic [CUR_W-1:0] tgt_code
);
    import chg_pkg::*;

    localparam int PROD_W = CUR_W + 4;

    logic [3:0]        mul;
    logic [PROD_W-1:0] prod;
    logic [CUR_W-1:0]  fast_eff;

    // eighths kept: 8 - factor, so 0 keeps all and 7 keeps one eighth
    always_comb begin
        mul      = 4'd8 - {1'b0, cool_fac};
        prod     = PROD_W'(fast_code) * PROD_W'(mul);
        fast_eff = (zone == ZN_COOL) ? prod[CUR_W+2:3] : fast_code;
        tgt_code = bat_low ? pre_code : fast_eff;
    end

endmodule

// File: rtl/chg_term_gate.sv
module chg_term_gate (
    input  logic       cv_active,
    input  logic       below_term,
    input  logic       vindpm_act,
    input  logic       dppm_act,
    input  logic       therm_act,
    input  logic       supp_act,
    input  logic [2:0] zone,
    output logic       term_ok,
    output logic       limiting
);
    import chg_pkg::*;

    logic loop_block;

    always_comb begin
        loop_block = vindpm_act | dppm_act | therm_act;
        limiting   = loop_block | (zone == ZN_COOL) | (zone == ZN_WARM);
        term_ok    = cv_active & below_term & ~loop_block & ~supp_act
                     & (zone != ZN_WARM);
    end

endmodule

// File: rtl/chg_safety_tmr.sv
module chg_safety_tmr #(
    parameter int TMR_UNIT = 16,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             adv_en,
    input  logic             half,
    input  logic             pre_phase,
    input  logic [SEL_W-1:0] sel,
    output logic             expired
);
    localparam int MAX_LIM = TMR_UNIT << ((1 << SEL_W) - 1);
    localparam int ACC_W   = $clog2(2 * MAX_LIM + 1) + 1;

    logic [SEL_W-1:0] sel_q;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] lim_fast;
    logic [ACC_W-1:0] lim2;
    logic             restart;

    // acc counts half-ticks: +2 at full rate, +1 at half rate
    always_comb begin
        restart  = (sel != sel_q);
        lim_fast = ACC_W'(TMR_UNIT) << sel;
        lim2     = (pre_phase ? (lim_fast >> 2) : lim_fast) << 1;
        expired  = adv_en && (acc >= lim2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            acc   <= '0;
        end else begin
            sel_q <= sel;
            if (clr || restart)
                acc <= '0;
            else if (adv_en && tick && !expired)
                acc <= acc + (half ? ACC_W'(1) : ACC_W'(2));
        end
    end

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !clr) |=> (acc == '0));

endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl #(
    parameter int CUR_W       = 8,
    parameter int BLANK_TICKS = 2,
    parameter int TMR_UNIT    = 16,
    parameter int SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             inhibit_pin,
    input  logic             dis_bit,
    input  logic             vin_ok,
    input  logic             bat_low,
    input  logic             cv_active,
    input  logic             below_term,
    input  logic             vindpm_act,
    input  logic             dppm_act,
    input  logic             therm_act,
    input  logic             supp_act,
    input  logic [2:0]       zone,
    input  logic [CUR_W-1:0] fast_code,
    input  logic [CUR_W-1:0] pre_code,
    input  logic [2:0]       cool_fac,
    input  logic [SEL_W-1:0] tmr_sel,
    input  logic             tmr_x2,
    output logic             chg_on,
    output logic [CUR_W-1:0] cur_code,
    output logic             vreg_warm,
    output logic             safety_fault,
    output logic             charge_done
);
    import chg_pkg::*;

    localparam int GAP_W = $clog2(BLANK_TICKS + 1);

    chg_state_e       state, nxt;
    logic [GAP_W-1:0] gap_cnt;
    logic [CUR_W-1:0] tgt_code;
    logic             en_ok, cold_hot, term_ok, limiting, tmr_exp;
    logic             tmr_clr, tmr_adv, gap_end;

    chg_isel #(.CUR_W(CUR_W)) u_isel (
        .bat_low  (bat_low),
        .zone     (zone),
        .fast_code(fast_code),
        .pre_code (pre_code),
        .cool_fac (cool_fac),
        .tgt_code (tgt_code)
    );

    chg_term_gate u_term (
        .cv_active (cv_active),
        .below_term(below_term),
        .vindpm_act(vindpm_act),
        .dppm_act  (dppm_act),
        .therm_act (therm_act),
        .supp_act  (supp_act),
        .zone      (zone),
        .term_ok   (term_ok),
        .limiting  (limiting)
    );

    always_comb begin
        tmr_clr = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAULT);
        tmr_adv = (state == ST_GAP) || (state == ST_PRE) || (state == ST_FAST);
    end

    chg_safety_tmr #(.TMR_UNIT(TMR_UNIT), .SEL_W(SEL_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (tmr_clr),
        .adv_en   (tmr_adv),
        .half     (tmr_x2 && limiting),
        .pre_phase(bat_low),
        .sel      (tmr_sel),
        .expired  (tmr_exp)
    );

    always_comb begin
        en_ok    = !inhibit_pin && !dis_bit && vin_ok;
        cold_hot = (zone == ZN_COLD) || (zone == ZN_HOT);
        gap_end  = tick && (gap_cnt == GAP_W'(BLANK_TICKS - 1));
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (en_ok) nxt = ST_GAP;
            ST_GAP: begin
                if (!en_ok)        nxt = ST_IDLE;
                else if (tmr_exp)  nxt = ST_FAULT;
                else if (cold_hot) nxt = ST_PAUSE;
                else if (gap_end)  nxt = bat_low ? ST_PRE : ST_FAST;
            end
            ST_PRE: begin
                if (!en_ok)                     nxt = ST_IDLE;
                else if (tmr_exp)               nxt = ST_FAULT;
                else if (cold_hot)              nxt = ST_PAUSE;
                else if (tgt_code != cur_code)  nxt = ST_GAP;
                else if (!bat_low)              nxt = ST_GAP;
            end
            ST_FAST: begin
                if (!en_ok)                     nxt = ST_IDLE;
                else if (tmr_exp)               nxt = ST_FAULT;
                else if (cold_hot)              nxt = ST_PAUSE;
                else if (term_ok)               nxt = ST_DONE;
                else if (tgt_code != cur_code)  nxt = ST_GAP;
                else if (bat_low)               nxt = ST_GAP;
            end
            ST_PAUSE: begin
                if (!en_ok)         nxt = ST_IDLE;
                else if (!cold_hot) nxt = ST_GAP;
            end
            ST_DONE:  if (!en_ok) nxt = ST_IDLE;
            ST_FAULT: if (inhibit_pin || !vin_ok) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register with gap counter and applied code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            gap_cnt  <= '0;
            cur_code <= '0;
        end else begin
            state <= nxt;
            if (state != ST_GAP)
                gap_cnt <= '0;
            else if (tick)
                gap_cnt <= gap_cnt + GAP_W'(1);
            if ((state == ST_GAP) && ((nxt == ST_PRE) || (nxt == ST_FAST)))
                cur_code <= tgt_code;
        end
    end

    // outputs
    always_comb begin
        chg_on       = (state == ST_PRE) || (state == ST_FAST);
        safety_fault = (state == ST_FAULT);
        charge_done  = (state == ST_DONE);
        vreg_warm    = (zone == ZN_WARM);
    end

    a_r1_on_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        chg_on |-> $past(!inhibit_pin && !dis_bit && vin_ok));

    a_r5_code_moves_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_code) |-> $past(!chg_on));

    a_r6_done_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(charge_done) |-> $past(cv_active && below_term && !vindpm_act &&
            !dppm_act && !therm_act && !supp_act && (zone != ZN_WARM)));

    a_r7_fault_from_timer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(safety_fault) |-> $past(tmr_exp));

    a_r8_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(safety_fault) |-> $past(inhibit_pin || !vin_ok));

    a_r11_pause_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ((zone == ZN_COLD) || (zone == ZN_HOT)) |=> !chg_on);

endmodule

// File: tb/chg_seq_ctrl_tb.sv
`timescale 1ns/1ps
module chg_seq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       inhibit_pin = 1'b1, dis_bit = 1'b0, vin_ok = 1'b0, bat_low = 1'b0;
    logic       cv_active = 1'b0, below_term = 1'b0, vindpm_act = 1'b0, dppm_act = 1'b0;
    logic       therm_act = 1'b0, supp_act = 1'b0, tmr_x2 = 1'b0;
    logic [2:0] zone = 3'd0, cool_fac = 3'd0;
    logic [7:0] fast_code = 8'd100, pre_code = 8'd10;
    logic [1:0] tmr_sel = 2'd3;
    logic       chg_on, vreg_warm, safety_fault, charge_done;
    logic [7:0] cur_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    chg_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .inhibit_pin(inhibit_pin),
        .dis_bit(dis_bit), .vin_ok(vin_ok), .bat_low(bat_low),
        .cv_active(cv_active), .below_term(below_term), .vindpm_act(vindpm_act),
        .dppm_act(dppm_act), .therm_act(therm_act), .supp_act(supp_act),
        .zone(zone), .fast_code(fast_code), .pre_code(pre_code),
        .cool_fac(cool_fac), .tmr_sel(tmr_sel), .tmr_x2(tmr_x2),
        .chg_on(chg_on), .cur_code(cur_code), .vreg_warm(vreg_warm),
        .safety_fault(safety_fault), .charge_done(charge_done)
    );

    typedef struct packed {
        logic [2:0] zn;
        logic       bl;
        logic [7:0] fc;
        logic [2:0] fac;
        logic       x_on;
        logic [7:0] x_code;
        logic       x_warm;
    } vec_t;

    // zone, bat_low, fast_code, cool_fac | expected chg_on, cur_code, vreg_warm
    localparam vec_t VECS [9] = '{
        '{3'd0, 1'b0, 8'd100, 3'd0, 1'b1, 8'd100, 1'b0},
        '{3'd0, 1'b1, 8'd100, 3'd0, 1'b1, 8'd10,  1'b0},
        '{3'd1, 1'b0, 8'd12,  3'd7, 1'b1, 8'd1,   1'b0},
        '{3'd1, 1'b0, 8'd100, 3'd4, 1'b1, 8'd50,  1'b0},
        '{3'd2, 1'b0, 8'd100, 3'd0, 1'b1, 8'd100, 1'b1},
        '{3'd3, 1'b0, 8'd100, 3'd0, 1'b0, 8'd100, 1'b0},
        '{3'd4, 1'b0, 8'd100, 3'd0, 1'b0, 8'd100, 1'b0},
        '{3'd0, 1'b0, 8'd200, 3'd0, 1'b1, 8'd200, 1'b0},
        '{3'd1, 1'b0, 8'd200, 3'd0, 1'b1, 8'd200, 1'b0}
    };

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sel_restart();
        tmr_sel = 2'd1;
        idle(1);
        tmr_sel = 2'd0;
        idle(1);
    endtask

    task automatic pin_toggle();
        inhibit_pin = 1'b1;
        idle(1);
        inhibit_pin = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R12 run: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R12 chg_on after reset", chg_on, 0);
        check("R12 cur_code after reset", cur_code, 0);
        check("R12 safety_fault after reset", safety_fault, 0);
        check("R12 charge_done after reset", charge_done, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R1: enable combinations
        vin_ok = 1'b1; inhibit_pin = 1'b1; dis_bit = 1'b0;
        do_ticks(4);
        check("R1 pin high", chg_on, 0);
        inhibit_pin = 1'b0; dis_bit = 1'b1;
        do_ticks(4);
        check("R1 disable bit set", chg_on, 0);
        dis_bit = 1'b0; vin_ok = 1'b0;
        do_ticks(4);
        check("R1 no supply", chg_on, 0);
        vin_ok = 1'b1;
        idle(1);
        do_ticks(2);
        check("R1 all enabled", chg_on, 1);
        check("R1 initial code", cur_code, 100);

        // R5: blanking gap
        fast_code = 8'd60;
        idle(3);
        check("R5 off during gap", chg_on, 0);
        check("R5 old code held", cur_code, 100);
        do_ticks(1);
        check("R5 still off after one tick", chg_on, 0);
        do_ticks(1);
        check("R5 on after gap", chg_on, 1);
        check("R5 new code", cur_code, 60);

        // table walk: R2 R3 R4 R11
        for (int v = 0; v < 9; v++) begin
            zone = VECS[v].zn; bat_low = VECS[v].bl;
            fast_code = VECS[v].fc; cool_fac = VECS[v].fac;
            do_ticks(4);
            checks++;
            if (chg_on !== VECS[v].x_on || cur_code !== VECS[v].x_code ||
                vreg_warm !== VECS[v].x_warm) begin
                errors++;
                $display("FAIL table vector %0d (R2 R3 R4 R11): actual on=%0d code=%0d warm=%0d expected on=%0d code=%0d warm=%0d",
                         v, chg_on, cur_code, vreg_warm,
                         VECS[v].x_on, VECS[v].x_code, VECS[v].x_warm);
            end
        end
        zone = 3'd0;
        idle(2);

        // R6: termination gating
        cv_active = 1'b1; below_term = 1'b1; therm_act = 1'b1;
        idle(3);
        check("R6 blocked by thermal loop", charge_done, 0);
        therm_act = 1'b0; zone = 3'd2;
        idle(3);
        check("R6 blocked in warm zone", charge_done, 0);
        zone = 3'd0; supp_act = 1'b1;
        idle(3);
        check("R6 blocked in supplement", charge_done, 0);
        supp_act = 1'b0; vindpm_act = 1'b1;
        idle(3);
        check("R6 blocked by input loop", charge_done, 0);
        vindpm_act = 1'b0;
        idle(2);
        check("R6 terminates when clean", charge_done, 1);
        check("R6 charging off when done", chg_on, 0);
        cv_active = 1'b0; below_term = 1'b0;
        pin_toggle();
        do_ticks(2);
        check("R6 restarts after pin toggle", chg_on, 1);

        // R9 and R7: restart, then plain fast limit of 16 ticks
        tmr_sel = 2'd0;
        idle(2);
        do_ticks(12);
        pulse_sel_restart();
        do_ticks(12);
        check("R9 restart on sel rewrite", safety_fault, 0);
        do_ticks(3);
        check("R7 one tick short", safety_fault, 0);
        do_ticks(1);
        idle(1);
        check("R7 fault at limit", safety_fault, 1);
        check("R7 charging off on fault", chg_on, 0);

        // R8: clearing rules
        dis_bit = 1'b1;
        idle(3);
        dis_bit = 1'b0;
        idle(3);
        check("R8 disable bit does not clear", safety_fault, 1);
        pin_toggle();
        check("R8 pin toggle clears", safety_fault, 0);
        do_ticks(2);
        check("R8 charging resumes", chg_on, 1);

        // R10: half rate with thermal loop
        pulse_sel_restart();
        tmr_x2 = 1'b1; therm_act = 1'b1;
        do_ticks(31);
        check("R10 half rate not yet expired", safety_fault, 0);
        do_ticks(1);
        idle(1);
        check("R10 half rate expiry", safety_fault, 1);
        tmr_x2 = 1'b0; therm_act = 1'b0;
        pin_toggle();
        do_ticks(2);

        // R11: pause holds the timer
        pulse_sel_restart();
        do_ticks(10);
        zone = 3'd3;
        idle(2);
        check("R11 cold stops charging", chg_on, 0);
        do_ticks(20);
        zone = 3'd0;
        idle(1);
        do_ticks(2);
        check("R11 timer held through pause", safety_fault, 0);
        check("R11 charging resumes", chg_on, 1);
        do_ticks(3);
        check("R11 held count one short", safety_fault, 0);
        do_ticks(1);
        idle(1);
        check("R11 held count expires", safety_fault, 1);

        // R7 and R2: pre-charge quarter limit
        bat_low = 1'b1;
        pin_toggle();
        do_ticks(2);
        do_ticks(1);
        check("R2 pre code applied", cur_code, 10);
        check("R7 pre one tick short", safety_fault, 0);
        do_ticks(1);
        idle(1);
        check("R7 pre quarter limit", safety_fault, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule